// File: doc/BRIEF.md
# Keyboard Host-Command Response Queue

This block sits behind one serial channel on the keyboard side and feeds the host a stream of bytes from a single queue. The queue is filled from two places. Raw key events arrive as a 7-bit scan index plus a release flag, and each is translated through a fixed 128-entry lookup table set by a parameter. Bytes the host writes to the channel's transmit register are decoded as keyboard commands, and the two commands the block knows are answered with canned reply sequences.

The host drains the queue one byte per read of the channel's receive-data port. A receive-available flag stays high while the queue holds at least one byte, so it rises again after every pop that leaves data behind. A push that finds too little room is dropped whole. A pop from an empty queue returns zero. When a key event and a command reply arrive in the same cycle, the reply bytes are queued before the key byte.

Top module: `kbq_resp_queue`

## Requirements
- R1: After reset the queue is empty, `rx_avail` is 0 and `rd_data` reads 0x00.
- R2: A key event with `key_code` = {rel, idx[6:0]} queues the byte KEYMAP[idx] OR (rel << 7). With the default map, entry idx is (5*idx + 3) mod 128.
- R3: The queue holds 256 bytes. A key event that arrives while it is full is discarded and leaves the stored bytes unchanged.
- R4: `rd_data` reads 0x00 whenever the queue is empty. A pop of an empty queue moves no pointer, so the next byte pushed is the next byte read.
- R5: `rx_avail` is 1 in the cycle after any accepted push. After a pop it stays 1 if any byte remains, and it drops to 0 in the cycle after the last byte is popped.
- R6: A transmit write of 0x01 queues 0xFF, 0xFF, 0x05, in that order.
- R7: A transmit write of 0x07 queues 0xFE and then 0x20.
- R8: A transmit write of any value other than 0x01 or 0x07 queues nothing.
- R9: If a command reply and a key event arrive in the same cycle, the reply bytes are queued ahead of the key byte.
- R10: A reply is queued only when the queue has free room for all of its bytes, otherwise none of its bytes are queued. In that case a key event in the same cycle is still queued if one slot is free.
- R11: Bytes are read out in the order they were queued, across pointer wrap and when a push and a pop happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | A key event is presented this cycle |
| key_code | input | 8 | Bit 7 is the release flag, bits 6:0 are the scan index |
| tx_wr | input | 1 | The host writes the transmit register this cycle |
| tx_data | input | 8 | The byte written to the transmit register |
| rd_pop | input | 1 | The host reads the receive-data port this cycle |
| rd_data | output | 8 | The byte at the head of the queue, or 0x00 when the queue is empty |
| rx_avail | output | 1 | The queue holds at least one byte |

## Verification
A wrong occupancy count shows at the ports within a cycle. Either `rx_avail` disagrees with what has been pushed and popped, or `rd_data` returns 0x00 where a byte was expected, or a byte shows up after the queue should have run dry. A bad read or write pointer corrupts the byte order. That shows on the very next read, or after a full drain when the pointers wrap. The directed tests fill the queue to exactly 254 and 256 entries so that a wrong free-room comparison is exposed: a reply is then split or wrongly admitted, and a key that should be dropped is stored.

// File: rtl/kbq_pkg.sv
package kbq_pkg;

    localparam int BYTE_W    = 8;
    localparam int MAP_SIZE  = 128;
    localparam int MAX_PUSH  = 4;              // longest reply plus one key byte
    localparam int MAX_REPLY = MAX_PUSH - 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef byte_t [MAP_SIZE-1:0] keymap_t;

    typedef enum logic [7:0] {
        CMD_RESET  = 8'h01,
        CMD_LAYOUT = 8'h07
    } host_cmd_e;

    typedef struct packed {
        logic [1:0]                 len;   // number of valid reply bytes
        byte_t [MAX_REPLY-1:0]      data;  // data[0] is queued first
    } reply_t;

    function automatic keymap_t default_keymap();
        keymap_t m;
        for (int i = 0; i < MAP_SIZE; i++) begin
            m[i] = byte_t'((5 * i + 3) % 128);
        end
        return m;
    endfunction

endpackage

// File: rtl/kbq_keymap.sv
module kbq_keymap
    import kbq_pkg::*;
#(
    parameter keymap_t MAP = default_keymap()
) (
    input  byte_t ev_code,
    output byte_t ev_byte
);
    // Release flag rides through untouched on the top bit.
    assign ev_byte = MAP[ev_code[6:0]] | {ev_code[7], 7'b0};
endmodule

// File: rtl/kbq_cmd_decode.sv
module kbq_cmd_decode
    import kbq_pkg::*;
(
    input  logic   wr,
    input  byte_t  cmd,
    output reply_t reply
);
    always_comb begin
        reply = '0;
        if (wr) begin
            case (cmd)
                CMD_RESET: begin
                    reply.len     = 2'd3;
                    reply.data[0] = 8'hFF;
                    reply.data[1] = 8'hFF;
                    reply.data[2] = 8'h05;
                end
                CMD_LAYOUT: begin
                    reply.len     = 2'd2;
                    reply.data[0] = 8'hFE;
                    reply.data[1] = 8'h20;
                end
                default: reply = '0;
            endcase
        end
    end
endmodule

// File: rtl/kbq_fifo.sv
module kbq_fifo
    import kbq_pkg::*;
#(
    parameter int DEPTH = 256,   // power of two
    parameter int SLOTS = MAX_PUSH
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(SLOTS+1)-1:0]   push_n,
    input  byte_t [SLOTS-1:0]            push_data,
    input  logic                         pop,
    output byte_t                        head,
    output logic [$clog2(DEPTH):0]       occ
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    byte_t          mem [DEPTH];
    logic [AW-1:0]  wptr, rptr;
    logic           pop_ok;

    assign pop_ok = pop && (occ != '0);
    assign head   = (occ != '0) ? mem[rptr] : '0;

    always_ff @(posedge clk) begin
        for (int k = 0; k < SLOTS; k++) begin
            if (k < int'(push_n)) begin
                mem[wptr + AW'(k)] <= push_data[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            occ  <= '0;
        end else begin
            wptr <= wptr + AW'(push_n);
            rptr <= rptr + AW'(pop_ok);
            occ  <= occ - CW'(pop_ok) + CW'(push_n);
        end
    end
endmodule

// File: rtl/kbq_resp_queue.sv
module kbq_resp_queue
    import kbq_pkg::*;
#(
    parameter int      DEPTH  = 256,
    parameter keymap_t KEYMAP = default_keymap()
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       key_valid,
    input  logic [7:0] key_code,
    input  logic       tx_wr,
    input  logic [7:0] tx_data,
    input  logic       rd_pop,
    output logic [7:0] rd_data,
    output logic       rx_avail
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam int NW = $clog2(MAX_PUSH + 1);

    byte_t                  key_byte;
    reply_t                 reply;
    logic [CW-1:0]          occ;
    logic [CW-1:0]          free_cnt;
    logic [NW-1:0]          rep_n;
    logic                   key_fit;
    logic [NW-1:0]          push_n;
    byte_t [MAX_PUSH-1:0]   slot;

    kbq_keymap #(.MAP(KEYMAP)) keymap_i (
        .ev_code (key_code),
        .ev_byte (key_byte)
    );

    kbq_cmd_decode cmd_i (
        .wr    (tx_wr),
        .cmd   (tx_data),
        .reply (reply)
    );

    assign free_cnt = CW'(DEPTH) - occ;

    // Replies go in whole or not at all; the key takes the slot after them.
    always_comb begin
        rep_n = '0;
        if (reply.len != 2'd0 && free_cnt >= CW'(reply.len)) begin
            rep_n = NW'(reply.len);
        end
        key_fit = key_valid && (free_cnt > CW'(rep_n));
        push_n  = rep_n + NW'(key_fit);

        slot = '0;
        for (int k = 0; k < MAX_REPLY; k++) begin
            slot[k] = reply.data[k];
        end
        slot[rep_n] = key_byte;
    end

    kbq_fifo #(.DEPTH(DEPTH), .SLOTS(MAX_PUSH)) fifo_i (
        .clk       (clk),
        .rst       (rst),
        .push_n    (push_n),
        .push_data (slot),
        .pop       (rd_pop),
        .head      (rd_data),
        .occ       (occ)
    );

    assign rx_avail = (occ != '0);
endmodule

// File: rtl/kbq_resp_queue_chk.sv
module kbq_resp_queue_chk #(
    parameter int DEPTH = 256
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     key_valid,
    input logic                     tx_wr,
    input logic [7:0]               tx_data,
    input logic                     rd_pop,
    input logic [7:0]               rd_data,
    input logic                     rx_avail,
    input logic [$clog2(DEPTH):0]   occ
);
    localparam int CW = $clog2(DEPTH) + 1;

    assert_occ_bound_R3: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(DEPTH));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (occ == CW'(DEPTH) && !rd_pop) |=> occ == CW'(DEPTH));

    assert_empty_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !rx_avail |-> rd_data == 8'h00);

    assert_avail_after_key_R5: assert property (@(posedge clk) disable iff (rst)
        key_valid |=> rx_avail);

    assert_reset_reply_len_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && tx_data == 8'h01 && !key_valid && !rd_pop && occ <= CW'(DEPTH - 3))
        |=> occ == $past(occ) + CW'(3));

    assert_other_cmd_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && tx_data != 8'h01 && tx_data != 8'h07 && !key_valid && !rd_pop)
        |=> $stable(occ));

    assert_reply_atomic_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && tx_data == 8'h01 && !key_valid && !rd_pop && occ > CW'(DEPTH - 3))
        |=> $stable(occ));
endmodule

bind kbq_resp_queue kbq_resp_queue_chk #(.DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .key_valid (key_valid),
    .tx_wr     (tx_wr),
    .tx_data   (tx_data),
    .rd_pop    (rd_pop),
    .rd_data   (rd_data),
    .rx_avail  (rx_avail),
    .occ       (occ)
);

// File: tb/kbq_resp_queue_tb_top.sv
`timescale 1ns/1ps
module kbq_resp_queue_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_valid = 1'b0;
    logic [7:0] key_code = '0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = '0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       rx_avail;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    kbq_resp_queue dut_i (
        .clk       (clk),
        .rst       (rst),
        .key_valid (key_valid),
        .key_code  (key_code),
        .tx_wr     (tx_wr),
        .tx_data   (tx_data),
        .rd_pop    (rd_pop),
        .rd_data   (rd_data),
        .rx_avail  (rx_avail)
    );

    function automatic logic [7:0] mapv(input logic [7:0] k);
        return 8'((5 * int'(k[6:0]) + 3) % 128) | (k & 8'h80);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic kv, input logic [7:0] kc,
                        input logic tv, input logic [7:0] td);
        @(negedge clk);
        key_valid = kv; key_code = kc; tx_wr = tv; tx_data = td;
        @(posedge clk); #1;
        key_valid = 1'b0; tx_wr = 1'b0;
    endtask

    task automatic pop_exp(input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_pop = 1'b1;
        #1 chk(req, rd_data, exp);
        @(posedge clk); #1;
        rd_pop = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 rx_avail", 8'(rx_avail), 8'h00);
        chk("R1 rd_data", rd_data, 8'h00);
    endtask

    task automatic t_translate();
        step(1'b1, 8'h00, 1'b0, 8'h00);
        step(1'b1, 8'h05, 1'b0, 8'h00);
        step(1'b1, 8'h85, 1'b0, 8'h00);
        step(1'b1, 8'hFF, 1'b0, 8'h00);
        pop_exp(8'h03, "R2 idx0");
        pop_exp(8'h1C, "R2 idx5");
        pop_exp(8'h9C, "R2 release idx5");
        pop_exp(mapv(8'hFF), "R2 release idx127");
    endtask

    task automatic t_avail();
        step(1'b1, 8'h10, 1'b0, 8'h00);
        chk("R5 set after push", 8'(rx_avail), 8'h01);
        step(1'b1, 8'h11, 1'b0, 8'h00);
        pop_exp(mapv(8'h10), "R5 first");
        chk("R5 rearm with data left", 8'(rx_avail), 8'h01);
        pop_exp(mapv(8'h11), "R5 last");
        chk("R5 drop when empty", 8'(rx_avail), 8'h00);
    endtask

    task automatic t_cmds();
        step(1'b0, 8'h00, 1'b1, 8'h01);
        pop_exp(8'hFF, "R6 byte0");
        pop_exp(8'hFF, "R6 byte1");
        pop_exp(8'h05, "R6 byte2");
        chk("R6 length", 8'(rx_avail), 8'h00);
        step(1'b0, 8'h00, 1'b1, 8'h07);
        pop_exp(8'hFE, "R7 byte0");
        pop_exp(8'h20, "R7 byte1");
        chk("R7 length", 8'(rx_avail), 8'h00);
        step(1'b0, 8'h00, 1'b1, 8'h00);
        step(1'b0, 8'h00, 1'b1, 8'h02);
        step(1'b0, 8'h00, 1'b1, 8'h81);
        step(1'b0, 8'h00, 1'b1, 8'hFE);
        chk("R8 nothing queued", 8'(rx_avail), 8'h00);
        pop_exp(8'h00, "R8 reads empty");
    endtask

    task automatic t_same_cycle();
        step(1'b1, 8'h01, 1'b1, 8'h07);
        pop_exp(8'hFE, "R9 reply first");
        pop_exp(8'h20, "R9 reply second");
        pop_exp(mapv(8'h01), "R9 key last");
    endtask

    task automatic t_empty_pop();
        pop_exp(8'h00, "R4 empty pop");
        pop_exp(8'h00, "R4 empty pop again");
        step(1'b1, 8'h2A, 1'b0, 8'h00);
        pop_exp(mapv(8'h2A), "R4 pointers unchanged");
        chk("R4 empty after", 8'(rx_avail), 8'h00);
    endtask

    task automatic t_full();
        for (int i = 0; i < 256; i++) step(1'b1, 8'(i), 1'b0, 8'h00);
        step(1'b1, 8'h33, 1'b0, 8'h00);
        for (int i = 0; i < 256; i++) pop_exp(mapv(8'(i)), "R3/R11 full order");
        pop_exp(8'h00, "R3 overflow discarded");
    endtask

    task automatic t_atomic();
        for (int i = 0; i < 254; i++) step(1'b1, 8'(i + 7), 1'b0, 8'h00);
        step(1'b1, 8'h2B, 1'b1, 8'h01);
        for (int i = 0; i < 254; i++) pop_exp(mapv(8'(i + 7)), "R10 prefill");
        pop_exp(mapv(8'h2B), "R10 key kept, reply dropped");
        pop_exp(8'h00, "R10 no partial reply");
    endtask

    task automatic t_push_pop();
        step(1'b1, 8'h44, 1'b0, 8'h00);
        @(negedge clk);
        rd_pop = 1'b1; key_valid = 1'b1; key_code = 8'h45;
        #1 chk("R11 head during push", rd_data, mapv(8'h44));
        @(posedge clk); #1;
        rd_pop = 1'b0; key_valid = 1'b0;
        chk("R11 avail kept", 8'(rx_avail), 8'h01);
        pop_exp(mapv(8'h45), "R11 pushed byte");
        chk("R11 empty", 8'(rx_avail), 8'h00);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_translate();
                t_avail();
                t_cmds();
                t_same_cycle();
                t_empty_pop();
                t_full();
                t_atomic();
                t_push_pop();
            end
            begin
                #1_000_000;
                vectors++;
                miscompares++;
                $display("FAIL R11 watchdog actual=timeout expected=completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule